// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank

This block is the 32-bit configuration register space of a DRAM controller, guarded by a protection word at byte offset 0x00. A bus master writes one of two magic keys, or any other value, to that word. The value decides whether writes to the other configuration registers take effect. There are three lock states. Open lets every write through. Soft-locked drops writes to protected registers but still accepts a new key. Hard-locked drops every protected write, including a new key, until reset.

A handful of registers are exempt from protection and take writes in every state. Three registers shape the data written to them. In the configuration word, read-only fields keep fixed values. The PHY status word never shows busy and always shows PLL lock. The ECC self-test control word always shows finished and never shows fail. A second window of words starting at byte 0x400 holds PHY status. Its first word comes out of reset with only bit 1 set. Reads are combinational on the address. Writes land on the rising clock edge.

Top module: `dram_cfg_regfile`

## Requirements
- R1: After reset, the protection word reads 0x00 (soft-locked). The configuration word at 0x04 reads its fixed value, 0x3000000C ORed with the RAM-size code. The word at 0x400 reads 0x00000002. Every other word reads zero.
- R2: Writing 0xFC600309 to offset 0x00 while not hard-locked makes the protection word read 0x01 (open).
- R3: Writing 0xDEADDEAD to offset 0x00 while not hard-locked makes the protection word read 0x10 (hard-locked). While hard-locked, no protected write, including one to offset 0x00, changes any register until reset.
- R4: Writing any other value to offset 0x00 while not hard-locked makes the protection word read 0x00. While it reads 0x00, writes to protected registers other than offset 0x00 are dropped.
- R5: Offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 store the written data unchanged in every lock state.
- R6: A write to offset 0x04 keeps these bits at fixed values: bits 31:28 = 3, bit 19 = 0, bits 18:14 = 0, bit 6 = 0, bits 3:2 = 0b11, and bits 1:0 = RAM-size code. All other bits take the written data.
- R7: A write to offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R8: A write to offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R9: The RAM-size code is the index of the size parameter in the list 256, 512, 1024, 2048 MiB. The default is 1024 MiB, which gives code 2.
- R10: Word addresses outside 0x000–0x0FC and 0x400–0x4FC read zero, and writes to them are dropped.
- R11: The low two address bits are ignored, so a byte address selects the word that contains it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W (12) | Byte address shared by read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |

## Verification
Each write takes effect on the rising edge where `wr_en` is sampled. The new register value, including the new lock state, is visible on `rd_data` at the next falling edge with no further delay, because reads are combinational. Every bench task drives a write at a falling edge and drops the strobe one full cycle later. It then moves the address and samples one time step after that falling edge, so each check lands exactly one cycle after its stimulus. Blocked-write checks read back the targeted register in that same slot, so a write that should have been dropped is caught before the next stimulus.

// File: rtl/dram_cfg_pkg.sv
package dram_cfg_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    localparam logic [31:0] KEY_OPEN      = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARD      = 32'hDEAD_DEAD;
    localparam logic [31:0] LOCKWORD_OPEN = 32'h0000_0001;
    localparam logic [31:0] LOCKWORD_HARD = 32'h0000_0010;

    // word indices (byte offset / 4) whose behaviour is special
    localparam logic [31:0] W_LOCK = 32'd0;
    localparam logic [31:0] W_CONF = 32'd1;
    localparam logic [31:0] W_STAT = 32'd24;   // 0x60
    localparam logic [31:0] W_ECC  = 32'd28;   // 0x70

    // configuration word: bits held at fixed values on every write
    localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04F;
    localparam logic [31:0] CONF_BASE    = 32'h3000_000C;

    localparam logic [31:0] PHY_STATUS_RESET = 32'h0000_0002;

    function automatic logic [1:0] size_code(input int mib);
        case (mib)
            256:     return 2'd0;
            512:     return 2'd1;
            1024:    return 2'd2;
            2048:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [31:0] conf_fixed(input logic [1:0] code);
        return CONF_BASE | {30'd0, code};
    endfunction

    function automatic logic is_open_word(input logic [31:0] w);
        case (w)
            32'h14, 32'h1B, 32'h1D, 32'h1E,
            32'h1F, 32'h22, 32'h23, 32'h2D: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] shape_word(input logic [31:0] w,
                                               input logic [31:0] d,
                                               input logic [1:0]  code);
        logic [31:0] r;
        r = d;
        if (w == W_CONF) begin
            r = (d & ~CONF_RO_MASK) | conf_fixed(code);
        end else if (w == W_STAT) begin
            r[0] = 1'b0;
            r[4] = 1'b1;
        end else if (w == W_ECC) begin
            r[12] = 1'b1;
            r[13] = 1'b0;
        end
        return r;
    endfunction

    function automatic lock_e key_decode(input logic [31:0] d);
        if (d == KEY_OPEN)      return LK_OPEN;
        else if (d == KEY_HARD) return LK_HARD;
        else                    return LK_SOFT;
    endfunction

    function automatic logic [31:0] lock_word(input lock_e s);
        case (s)
            LK_OPEN: return LOCKWORD_OPEN;
            LK_HARD: return LOCKWORD_HARD;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/dram_cfg_lock.sv
module dram_cfg_lock
    import dram_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_we,
    input  logic [31:0] key_data,
    output lock_e       state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_SOFT;
        end else if (key_we && state != LK_HARD) begin
            state <= key_decode(key_data);
        end
    end

endmodule

// File: rtl/dram_cfg_decode.sv
module dram_cfg_decode
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MAIN_WORDS = 64,
    parameter int PHY_BASE   = 256,
    parameter int PHY_WORDS  = 64,
    parameter logic [1:0] SIZE_CODE = 2'd2,
    localparam int SLOTS     = MAIN_WORDS + PHY_WORDS,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  lock_e             lock,
    output logic              hit,
    output logic              is_lock,
    output logic [SLOT_W-1:0] slot,
    output logic              key_we,
    output logic              bank_we,
    output logic [31:0]       bank_data
);

    localparam logic [31:0] MAIN_L  = 32'(MAIN_WORDS);
    localparam logic [31:0] PBASE_L = 32'(PHY_BASE);
    localparam logic [31:0] PEND_L  = 32'(PHY_BASE + PHY_WORDS);

    logic [31:0] word;
    logic [31:0] phy_off;
    logic        in_main;
    logic        in_phy;
    logic        open_w;

    always_comb begin
        word    = 32'(addr[ADDR_W-1:2]);
        in_main = word < MAIN_L;
        in_phy  = (word >= PBASE_L) && (word < PEND_L);
        phy_off = word - PBASE_L + MAIN_L;
        hit     = in_main || in_phy;
        slot    = in_main ? word[SLOT_W-1:0] : phy_off[SLOT_W-1:0];
        is_lock = in_main && (word == W_LOCK);
        open_w  = in_main && is_open_word(word);

        key_we    = wr_en && is_lock && (lock != LK_HARD);
        bank_we   = wr_en && hit && !is_lock && (open_w || lock == LK_OPEN);
        bank_data = open_w ? wr_data : shape_word(word, wr_data, SIZE_CODE);
    end

endmodule

// File: rtl/dram_cfg_bank.sv
module dram_cfg_bank
    import dram_cfg_pkg::*;
#(
    parameter int MAIN_WORDS = 64,
    parameter int PHY_WORDS  = 64,
    parameter logic [1:0] SIZE_CODE = 2'd2,
    localparam int SLOTS     = MAIN_WORDS + PHY_WORDS,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SLOT_W-1:0]      wslot,
    input  logic [31:0]            wdata,
    output logic [SLOTS-1:0][31:0] words
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_word
        localparam logic [31:0] RST_VAL =
            (i == int'(W_CONF)) ? conf_fixed(SIZE_CODE) :
            (i == MAIN_WORDS)   ? PHY_STATUS_RESET      : 32'd0;

        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= RST_VAL;
            end else if (we && wslot == SLOT_W'(i)) begin
                words[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dram_cfg_regfile.sv
module dram_cfg_regfile
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int MAIN_WORDS = 64,
    parameter int PHY_BASE   = 256,
    parameter int PHY_WORDS  = 64,
    parameter int RAM_MIB    = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data
);

    localparam int SLOTS  = MAIN_WORDS + PHY_WORDS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [1:0] SIZE_CODE = size_code(RAM_MIB);

    lock_e                   lock_q;
    logic                    hit;
    logic                    is_lock;
    logic [SLOT_W-1:0]       slot;
    logic                    key_we;
    logic                    bank_we;
    logic [31:0]             bank_data;
    logic [SLOTS-1:0][31:0]  words;

    dram_cfg_decode #(
        .ADDR_W(ADDR_W), .MAIN_WORDS(MAIN_WORDS), .PHY_BASE(PHY_BASE),
        .PHY_WORDS(PHY_WORDS), .SIZE_CODE(SIZE_CODE)
    ) u_dec (
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .lock(lock_q),
        .hit(hit), .is_lock(is_lock), .slot(slot), .key_we(key_we),
        .bank_we(bank_we), .bank_data(bank_data)
    );

    dram_cfg_lock u_lock (
        .clk(clk), .rst(rst), .key_we(key_we), .key_data(wr_data),
        .state(lock_q)
    );

    dram_cfg_bank #(
        .MAIN_WORDS(MAIN_WORDS), .PHY_WORDS(PHY_WORDS), .SIZE_CODE(SIZE_CODE)
    ) u_bank (
        .clk(clk), .rst(rst), .we(bank_we), .wslot(slot), .wdata(bank_data),
        .words(words)
    );

    always_comb begin
        if (!hit)         rd_data = 32'd0;
        else if (is_lock) rd_data = lock_word(lock_q);
        else              rd_data = words[slot];
    end

endmodule

// File: rtl/dram_cfg_checker.sv
module dram_cfg_checker
    import dram_cfg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [1:0] SIZE_CODE = 2'd2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input lock_e             lock,
    input logic              bank_we,
    input logic [31:0]       conf_word,
    input logic [31:0]       stat_word,
    input logic [31:0]       ecc_word
);

    logic [31:0] w;
    assign w = 32'(addr[ADDR_W-1:2]);

    // R2
    a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w == W_LOCK && wr_data == KEY_OPEN && lock != LK_HARD)
        |=> lock == LK_OPEN);

    // R3
    a_r3_hard_sticky: assert property (@(posedge clk) disable iff (rst)
        lock == LK_HARD |=> lock == LK_HARD);

    // R4
    a_r4_locked_drops: assert property (@(posedge clk) disable iff (rst)
        !(lock != LK_OPEN && bank_we && !is_open_word(w)));

    // R5
    a_r5_open_accepts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_open_word(w)) |-> bank_we);

    // R6
    a_r6_conf_fixed: assert property (@(posedge clk) disable iff (rst)
        (conf_word & CONF_RO_MASK) == conf_fixed(SIZE_CODE));

    // R7
    a_r7_status_forced: assert property (@(posedge clk) disable iff (rst)
        (bank_we && w == W_STAT) |=> (!stat_word[0] && stat_word[4]));

    // R8
    a_r8_ecc_forced: assert property (@(posedge clk) disable iff (rst)
        (bank_we && w == W_ECC) |=> (ecc_word[12] && !ecc_word[13]));

endmodule

bind dram_cfg_regfile dram_cfg_checker #(
    .ADDR_W(ADDR_W), .SIZE_CODE(SIZE_CODE)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .lock(lock_q), .bank_we(bank_we),
    .conf_word(words[int'(dram_cfg_pkg::W_CONF)]),
    .stat_word(words[int'(dram_cfg_pkg::W_STAT)]),
    .ecc_word(words[int'(dram_cfg_pkg::W_ECC)])
);

// File: tb/dram_cfg_regfile_test.sv
module dram_cfg_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] CONF_RST = 32'h3000_000E;   // size code 2

    dram_cfg_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] exp,
                       input string req);
        addr = a; #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
                     req, a, rd_data, exp);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(12'h000, 32'h0, "R1");
        chk(12'h004, CONF_RST, "R1");
        chk(12'h400, 32'h2, "R1");
        chk(12'h008, 32'h0, "R1");
        chk(12'h060, 32'h0, "R1");
    endtask

    task automatic t_soft_blocks();
        wr(12'h008, 32'h1234_5678);
        chk(12'h008, 32'h0, "R4");
        wr(12'h004, 32'hFFFF_FFFF);
        chk(12'h004, CONF_RST, "R4");
    endtask

    task automatic t_open_regs();
        wr(12'h050, 32'hCAFE_0001); chk(12'h050, 32'hCAFE_0001, "R5");
        wr(12'h0B4, 32'h0000_3000); chk(12'h0B4, 32'h0000_3000, "R5");
        wr(12'h07C, 32'hFFFF_FFFF); chk(12'h07C, 32'hFFFF_FFFF, "R5");
    endtask

    task automatic t_unlock_and_shape();
        wr(12'h000, 32'hFC60_0309); chk(12'h000, 32'h1, "R2");
        wr(12'h004, 32'hFFFF_FFFF); chk(12'h004, 32'h3FF0_3FBE, "R6");
        wr(12'h004, 32'h0000_0000); chk(12'h004, CONF_RST, "R9");
        wr(12'h060, 32'h0000_0001); chk(12'h060, 32'h0000_0010, "R7");
        wr(12'h060, 32'hFFFF_FFFF); chk(12'h060, 32'hFFFF_FFFE, "R7");
        wr(12'h070, 32'h0000_2000); chk(12'h070, 32'h0000_1000, "R8");
        wr(12'h070, 32'hFFFF_FFFF); chk(12'h070, 32'hFFFF_DFFF, "R8");
        wr(12'h008, 32'hA5A5_5A5A); chk(12'h008, 32'hA5A5_5A5A, "R2");
        wr(12'h400, 32'h0000_0FF0); chk(12'h400, 32'h0000_0FF0, "R2");
    endtask

    task automatic t_range_and_align();
        wr(12'h200, 32'hDEAD_BEEF); chk(12'h200, 32'h0, "R10");
        chk(12'h204, 32'h0, "R10");
        wr(12'h00F, 32'h0BAD_F00D); chk(12'h00C, 32'h0BAD_F00D, "R11");
        chk(12'h00E, 32'h0BAD_F00D, "R11");
    endtask

    task automatic t_relock_soft();
        wr(12'h000, 32'h0000_1234); chk(12'h000, 32'h0, "R4");
        wr(12'h008, 32'h1111_1111); chk(12'h008, 32'hA5A5_5A5A, "R4");
        wr(12'h000, 32'hFC60_0309); chk(12'h000, 32'h1, "R2");
    endtask

    task automatic t_hard_lock();
        wr(12'h000, 32'hDEAD_DEAD); chk(12'h000, 32'h10, "R3");
        wr(12'h000, 32'hFC60_0309); chk(12'h000, 32'h10, "R3");
        wr(12'h000, 32'h0000_0000); chk(12'h000, 32'h10, "R3");
        wr(12'h008, 32'h2222_2222); chk(12'h008, 32'hA5A5_5A5A, "R3");
        wr(12'h088, 32'h0000_0088); chk(12'h088, 32'h0000_0088, "R5");
        do_reset();
        chk(12'h000, 32'h0, "R1");
        chk(12'h008, 32'h0, "R1");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_soft_blocks();
        t_open_regs();
        t_unlock_and_shape();
        t_range_and_align();
        t_relock_soft();
        t_hard_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule